// File: doc/BRIEF.md
# Serial Flash Command Engine

This block runs one command at a time against a serial flash device over a single-lane SPI link. Software fills in an address word, two write-data words and a clock divider, then writes a 32-bit control word whose lowest bit starts the command. The engine drives chip select low and sends the opcode. It then sends an optional address, an optional run of dummy clocks and finally either a write payload or a read payload, and releases chip select. Software polls a busy flag in the control word and then collects any captured bytes from two read-only words.

The register port is a plain synchronous write strobe with an index and a combinational read-back of the indexed word. The indices are 0 control, 1 address, 2 write data low, 3 write data high, 4 read data low, 5 read data high and 6 clock divider. The serial clock idles low. MOSI changes only after a falling SCLK edge and MISO is sampled on the rising edge.

Top module: `sfc_cmd_engine`

## Requirements
- R1: After reset every register index reads zero except the divider (index 6), which reads 1. CS_n is high, SCLK is low and the busy bit is clear.
- R2: A command sends the opcode (control bits 31:24), MSB first. If bit 19 is set, it then sends the address: (bits 17:16)+1 bytes from the low end of the address word, most significant byte first. It then gives (bits 11:7) dummy SCLK cycles with MOSI low, then the data phase. The total SCLK pulse count is 8 + 8·A + D + 8·N.
- R3: When bit 15 is set, (bits 14:12)+1 bytes are sent. Byte i comes from write-low bits 8i+7:8i for i<4, and from write-high bits 8(i-4)+7:8(i-4) otherwise. Bytes go out in increasing i, each MSB first, and no byte beyond the count is sent.
- R4: When bit 23 is set, (bits 22:20)+1 bytes are clocked in with MOSI low. MISO is sampled on rising SCLK and the first bit of a byte is its MSB. Byte i lands in the same lane of read-low/read-high that R3 uses. Lanes beyond the count keep their old value, and register writes to indices 4 and 5 have no effect.
- R5: SCLK is low whenever CS_n is high, and MOSI never changes in the cycle SCLK rises.
- R6: With divider field f (index 6, bits 3:0), each SCLK half period lasts f+1 clock cycles, so the divide ratio is the even value 2(f+1).
- R7: A control write with bit 0 set while idle makes busy (control bit 1) read 1 from the next cycle. CS_n is low exactly while busy, and busy clears when the last bit ends.
- R8: Control bit 0 always reads 0. Bits 31:2 other than busy read back as last written.
- R9: Every register write made while busy is ignored, including a second execute, which starts no command.
- R10: A command with no address, zero dummy cycles and no data sends exactly 8 SCLK pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read-back of the indexed register |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The assertions assume that MISO is stable around rising SCLK, and that no control word ever enables the read and write phases together. The engine does not define an order between those two phases. The bench's flash model therefore changes MISO only on falling SCLK edges, and its random command generator chooses none, write or read as one exclusive mode. The bench also assumes the divider never changes mid-command, which the engine's busy lock already ensures.

// File: rtl/sfc_pkg.sv
`timescale 1ns/1ps
package sfc_pkg;

   localparam int SEQ_BITS = 64;

   // register indices
   localparam logic [2:0] RI_CTRL = 3'd0;
   localparam logic [2:0] RI_ADDR = 3'd1;
   localparam logic [2:0] RI_WLO  = 3'd2;
   localparam logic [2:0] RI_WHI  = 3'd3;
   localparam logic [2:0] RI_RLO  = 3'd4;
   localparam logic [2:0] RI_RHI  = 3'd5;
   localparam logic [2:0] RI_DIV  = 3'd6;

   localparam int CTL_EXEC = 0;

   typedef enum logic [2:0] {
      PH_OPC, PH_ADR, PH_DUM, PH_WR, PH_RD, PH_END
   } phase_e;

   typedef struct packed {
      logic [7:0] op;
      logic       ren;
      logic [2:0] rcnt;
      logic       aen;
      logic [1:0] acnt;
      logic       wen;
      logic [2:0] wcnt;
      logic [4:0] dummy;
   } cmd_t;

   function automatic cmd_t decode_ctl(logic [31:0] w);
      cmd_t c;
      c.op    = w[31:24];
      c.ren   = w[23];
      c.rcnt  = w[22:20];
      c.aen   = w[19];
      c.acnt  = w[17:16];
      c.wen   = w[15];
      c.wcnt  = w[14:12];
      c.dummy = w[11:7];
      return c;
   endfunction

   function automatic phase_e next_phase(phase_e cur, cmd_t c);
      phase_e n;
      n = PH_END;
      case (cur)
         PH_OPC: begin
            if (c.aen)              n = PH_ADR;
            else if (c.dummy != 0)  n = PH_DUM;
            else if (c.wen)         n = PH_WR;
            else if (c.ren)         n = PH_RD;
         end
         PH_ADR: begin
            if (c.dummy != 0)       n = PH_DUM;
            else if (c.wen)         n = PH_WR;
            else if (c.ren)         n = PH_RD;
         end
         PH_DUM: begin
            if (c.wen)              n = PH_WR;
            else if (c.ren)         n = PH_RD;
         end
         default:                   n = PH_END;
      endcase
      return n;
   endfunction

   function automatic logic [6:0] phase_len(phase_e p, cmd_t c);
      logic [6:0] l;
      case (p)
         PH_OPC:  l = 7'd8;
         PH_ADR:  l = {1'b0, {1'b0, c.acnt} + 3'd1, 3'b000};
         PH_DUM:  l = {2'b00, c.dummy};
         PH_WR:   l = {{1'b0, c.wcnt} + 4'd1, 3'b000};
         PH_RD:   l = {{1'b0, c.rcnt} + 4'd1, 3'b000};
         default: l = 7'd0;
      endcase
      return l;
   endfunction

   function automatic logic [SEQ_BITS-1:0] phase_load(phase_e p, cmd_t c,
         logic [31:0] addr, logic [SEQ_BITS-1:0] wstream);
      logic [SEQ_BITS-1:0] v;
      case (p)
         PH_OPC:  v = {c.op, {(SEQ_BITS-8){1'b0}}};
         PH_ADR:  v = {addr << {~c.acnt, 3'b000}, 32'd0};
         PH_WR:   v = wstream;
         default: v = '0;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/sfc_clkdiv.sv
`timescale 1ns/1ps
module sfc_clkdiv #(
   parameter int DIV_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div_f,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;

   assign tick = run && (cnt_q == div_f);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (!run || tick)  cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/sfc_seq.sv
`timescale 1ns/1ps
module sfc_seq
   import sfc_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  cmd_t                cmd,
   input  logic [31:0]         addr,
   input  logic [SEQ_BITS-1:0] wstream,
   input  logic                tick,
   input  logic                miso,
   output logic                active,
   output logic                sclk,
   output logic                mosi,
   output logic                done,
   output logic                cap_we,
   output logic [2:0]          cap_idx,
   output logic [7:0]          cap_byte
);
   phase_e              phase_q;
   logic [5:0]          bit_q;
   logic [SEQ_BITS-1:0] tx_q;
   logic [6:0]          rx_q;
   logic                sclk_q, act_q;

   logic [6:0] len;
   logic       last, rise, fall;
   phase_e     nxt;

   assign len  = phase_len(phase_q, cmd);
   assign last = ({1'b0, bit_q} == len - 7'd1);
   assign nxt  = next_phase(phase_q, cmd);
   assign rise = act_q && tick && !sclk_q;
   assign fall = act_q && tick && sclk_q;

   assign done     = fall && last && (nxt == PH_END);
   assign cap_we   = rise && (phase_q == PH_RD) && (bit_q[2:0] == 3'd7);
   assign cap_idx  = bit_q[5:3];
   assign cap_byte = {rx_q, miso};

   assign active = act_q;
   assign sclk   = sclk_q;
   assign mosi   = act_q && tx_q[SEQ_BITS-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_END;
         bit_q   <= '0;
         tx_q    <= '0;
         rx_q    <= '0;
         sclk_q  <= 1'b0;
         act_q   <= 1'b0;
      end else if (start && !act_q) begin
         act_q   <= 1'b1;
         phase_q <= PH_OPC;
         bit_q   <= '0;
         sclk_q  <= 1'b0;
         tx_q    <= phase_load(PH_OPC, cmd, addr, wstream);
      end else if (rise) begin
         sclk_q <= 1'b1;
         if (phase_q == PH_RD) rx_q <= {rx_q[5:0], miso};
      end else if (fall) begin
         sclk_q <= 1'b0;
         if (last) begin
            if (nxt == PH_END) begin
               act_q <= 1'b0;
               tx_q  <= '0;
            end else begin
               phase_q <= nxt;
               bit_q   <= '0;
               tx_q    <= phase_load(nxt, cmd, addr, wstream);
            end
         end else begin
            bit_q <= bit_q + 6'd1;
            tx_q  <= tx_q << 1;
         end
      end
   end
endmodule

// File: rtl/sfc_cmd_engine.sv
`timescale 1ns/1ps
module sfc_cmd_engine
   import sfc_pkg::*;
#(
   parameter int DIV_W     = 4,
   parameter int DIV_RESET = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_we,
   input  logic [2:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        spi_sclk,
   output logic        spi_cs_n,
   output logic        spi_mosi,
   input  logic        spi_miso
);
   localparam int NBYTE  = SEQ_BITS / 8;
   localparam int NLOW   = NBYTE / 2;

   initial begin : elab_chk
      assert (DIV_W >= 1 && DIV_W <= 8) else $fatal(1, "DIV_W out of range");
      assert (DIV_RESET >= 0 && DIV_RESET < (1 << DIV_W)) else $fatal(1, "DIV_RESET too wide");
   end

   logic [31:2]         ctl_q;
   logic [31:0]         addr_q, wlo_q, whi_q;
   logic [SEQ_BITS-1:0] rdat_q;
   logic [DIV_W-1:0]    div_q;
   logic                busy_q;

   logic wr_ok, start, done, tick, active;
   logic cap_we;
   logic [2:0] cap_idx;
   logic [7:0] cap_byte;
   cmd_t cmd;
   logic [SEQ_BITS-1:0] wstream;

   assign wr_ok = reg_we && !busy_q;
   assign start = wr_ok && (reg_addr == RI_CTRL) && reg_wdata[CTL_EXEC];
   assign cmd   = decode_ctl(start ? reg_wdata : {ctl_q, 2'b00});

   // byte 0 goes first: reverse the lane order into the serial stream
   for (genvar gi = 0; gi < NBYTE; gi++) begin : g_wlane
      if (gi < NLOW) begin : g_lo
         assign wstream[SEQ_BITS-1-8*gi -: 8] = wlo_q[8*gi +: 8];
      end else begin : g_hi
         assign wstream[SEQ_BITS-1-8*gi -: 8] = whi_q[8*(gi-NLOW) +: 8];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         addr_q <= '0;
         wlo_q  <= '0;
         whi_q  <= '0;
         div_q  <= DIV_W'(DIV_RESET);
      end else if (wr_ok) begin
         case (reg_addr)
            RI_CTRL: ctl_q  <= {reg_wdata[31:2]};
            RI_ADDR: addr_q <= reg_wdata;
            RI_WLO:  wlo_q  <= reg_wdata;
            RI_WHI:  whi_q  <= reg_wdata;
            RI_DIV:  div_q  <= reg_wdata[DIV_W-1:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     busy_q <= 1'b0;
      else if (start) busy_q <= 1'b1;
      else if (done)  busy_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdat_q <= '0;
      end else if (cap_we) begin
         for (int i = 0; i < NBYTE; i++)
            if (cap_idx == 3'(i)) rdat_q[8*i +: 8] <= cap_byte;
      end
   end

   always_comb begin
      case (reg_addr)
         RI_CTRL: reg_rdata = {ctl_q[31:2], busy_q, 1'b0} & 32'hFFFF_FFFE;
         RI_ADDR: reg_rdata = addr_q;
         RI_WLO:  reg_rdata = wlo_q;
         RI_WHI:  reg_rdata = whi_q;
         RI_RLO:  reg_rdata = rdat_q[31:0];
         RI_RHI:  reg_rdata = rdat_q[63:32];
         RI_DIV:  reg_rdata = 32'(div_q);
         default: reg_rdata = '0;
      endcase
   end

   sfc_clkdiv #(.DIV_W(DIV_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (active),
      .div_f (div_q),
      .tick  (tick)
   );

   sfc_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .cmd      (cmd),
      .addr     (addr_q),
      .wstream  (wstream),
      .tick     (tick),
      .miso     (spi_miso),
      .active   (active),
      .sclk     (spi_sclk),
      .mosi     (spi_mosi),
      .done     (done),
      .cap_we   (cap_we),
      .cap_idx  (cap_idx),
      .cap_byte (cap_byte)
   );

   assign spi_cs_n = !active;

endmodule

// File: rtl/sfc_cmd_engine_chk.sv
`timescale 1ns/1ps
module sfc_cmd_engine_chk #(
   parameter int DIV_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_we,
   input logic [2:0]       reg_addr,
   input logic [31:0]      reg_wdata,
   input logic             spi_sclk,
   input logic             spi_cs_n,
   input logic             spi_mosi,
   input logic             busy,
   input logic [31:0]      addr_q,
   input logic [DIV_W-1:0] div_q
);
   logic             sclk_d;
   logic [DIV_W:0]   hcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         hcnt   <= '0;
      end else begin
         sclk_d <= spi_sclk;
         if (spi_cs_n)               hcnt <= '0;
         else if (spi_sclk != sclk_d) hcnt <= (DIV_W+1)'(1);
         else                        hcnt <= hcnt + 1'b1;
      end
   end

   // R5: clock idles low outside a command
   p_sclk_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sclk);

   // R5: data is settled when the clock rises
   p_mosi_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_sclk) |-> $stable(spi_mosi));

   // R6: every half period inside a command lasts f+1 cycles
   p_half_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!spi_cs_n && spi_sclk != sclk_d) |-> (hcnt == {1'b0, div_q} + 1'b1));

   // R7: chip select and busy agree
   p_cs_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy == !spi_cs_n);

   // R7: an execute while idle starts a command next cycle
   p_exec_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && reg_we && reg_addr == 3'd0 && reg_wdata[0]) |=> (busy && !spi_cs_n));

   // R9: writes during a command leave the address and divider alone
   p_addr_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && reg_we) |=> $stable(addr_q));

   p_div_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && reg_we) |=> $stable(div_q));

endmodule

bind sfc_cmd_engine sfc_cmd_engine_chk #(.DIV_W(DIV_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .spi_sclk  (spi_sclk),
   .spi_cs_n  (spi_cs_n),
   .spi_mosi  (spi_mosi),
   .busy      (busy_q),
   .addr_q    (addr_q),
   .div_q     (div_q)
);

// File: tb/sfc_cmd_engine_tb.sv
`timescale 1ns/1ps
module sfc_cmd_engine_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        spi_sclk, spi_cs_n, spi_mosi;
   logic        spi_miso = 1'b0;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   sfc_cmd_engine u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
      .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
   );

   // flash model: records MOSI on rising SCLK, drives MISO on falling SCLK
   bit          mbits [0:255];
   int          rise_cnt = 0;
   longint      t_rise [0:1];
   logic [63:0] rd_stream = '0;
   int          rd_start = 0;

   always @(negedge spi_cs_n) rise_cnt = 0;

   always @(posedge spi_sclk) begin
      if (rise_cnt < 256) mbits[rise_cnt] = spi_mosi;
      if (rise_cnt < 2)   t_rise[rise_cnt] = $time;
      rise_cnt++;
   end

   always @(negedge spi_sclk) begin
      if (rise_cnt >= rd_start && rise_cnt - rd_start < 64)
         spi_miso = rd_stream[63 - (rise_cnt - rd_start)];
      else
         spi_miso = 1'b0;
   end

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic run_cmd(input logic [7:0] op, input int an, input logic [31:0] a,
                          input int dm, input int wn, input int rn,
                          input logic [63:0] w64, input logic [63:0] r64,
                          input int f, input bit intrude);
      logic [31:0] ctl, v, lo, hi, olo, ohi;
      logic [63:0] exp_rd;
      bit expb [0:255];
      int p, bad, len, cnt_after;
      ctl = {op, 24'd0};
      if (rn > 0) begin ctl[23] = 1'b1; ctl[22:20] = 3'(rn - 1); end
      if (an > 0) begin ctl[19] = 1'b1; ctl[17:16] = 2'(an - 1); end
      if (wn > 0) begin ctl[15] = 1'b1; ctl[14:12] = 3'(wn - 1); end
      ctl[11:7] = 5'(dm);
      ctl[0] = 1'b1;
      wr(3'd6, 32'(f)); wr(3'd1, a); wr(3'd2, w64[31:0]); wr(3'd3, w64[63:32]);
      rd(3'd4, olo); rd(3'd5, ohi);
      rd_stream = r64;
      rd_start = 8 + 8*an + dm;
      wr(3'd0, ctl);
      rd(3'd0, v);
      check(v[1] == 1'b1 && spi_cs_n == 1'b0, "R7 busy after execute", {v[1], spi_cs_n}, 2'b10);
      if (intrude) begin
         wr(3'd0, 32'h5A00_0001);
         wr(3'd1, 32'hDEAD_BEEF);
         wr(3'd6, 32'd9);
         wr(3'd4, 32'hFFFF_FFFF);
      end
      for (int k = 0; k < 20000; k++) begin
         rd(3'd0, v);
         if (!v[1]) break;
      end
      check(v[1] == 1'b0 && spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R7 busy clears at end",
            {v[1], spi_cs_n, spi_sclk}, 3'b010);
      // expected serial stream
      p = 0;
      for (int k = 7; k >= 0; k--) begin expb[p] = op[k]; p++; end
      for (int b = an - 1; b >= 0; b--)
         for (int k = 7; k >= 0; k--) begin expb[p] = a[8*b + k]; p++; end
      for (int k = 0; k < dm; k++) begin expb[p] = 1'b0; p++; end
      for (int i = 0; i < wn; i++)
         for (int k = 7; k >= 0; k--) begin expb[p] = w64[8*i + k]; p++; end
      for (int k = 0; k < 8*rn; k++) begin expb[p] = 1'b0; p++; end
      len = p;
      check(rise_cnt == len, (an == 0 && dm == 0 && wn == 0 && rn == 0) ? "R10 pulse count" : "R2 pulse count",
            64'(rise_cnt), 64'(len));
      bad = 0;
      for (int k = 0; k < len; k++) if (mbits[k] !== expb[k]) bad++;
      check(bad == 0, (wn > 0) ? "R3 write stream" : "R2 command stream", 64'(bad), 64'd0);
      check((t_rise[1] - t_rise[0]) == 64'(2*(f+1)*20), "R6 sclk period",
            64'(t_rise[1] - t_rise[0]), 64'(2*(f+1)*20));
      rd(3'd4, lo); rd(3'd5, hi);
      exp_rd = {ohi, olo};
      for (int i = 0; i < rn; i++) exp_rd[8*i +: 8] = r64[63 - 8*i -: 8];
      check({hi, lo} == exp_rd, "R4 read registers", {hi, lo}, exp_rd);
      rd(3'd0, v);
      check(v == (ctl & 32'hFFFF_FFFC), "R8 control readback", 64'(v), 64'(ctl & 32'hFFFF_FFFC));
      if (intrude) begin
         rd(3'd1, v);
         check(v == a, "R9 address write ignored", 64'(v), 64'(a));
         rd(3'd6, v);
         check(v == 32'(f), "R9 divider write ignored", 64'(v), 64'(f));
         cnt_after = rise_cnt;
         repeat (100) @(negedge clk);
         check(spi_cs_n == 1'b1 && rise_cnt == cnt_after, "R9 second execute ignored",
               {spi_cs_n, 32'(rise_cnt)}, {1'b1, 32'(cnt_after)});
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_err++;
         $display("FAIL R7 watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] v;
      logic [63:0] w, r;
      int an, dm, mode, n, f;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      check(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R1 pins in reset", {spi_cs_n, spi_sclk}, 2'b10);
      rst_n = 1'b1;
      for (int i = 0; i < 7; i++) begin
         rd(3'(i), v);
         check(v == ((i == 6) ? 32'd1 : 32'd0), "R1 reset register value", 64'(v), (i == 6) ? 64'd1 : 64'd0);
      end
      // R4: read-data registers are not writable
      wr(3'd4, 32'h1234_5678); wr(3'd5, 32'h9ABC_DEF0);
      rd(3'd4, v); check(v == 32'd0, "R4 read-low not writable", 64'(v), 64'd0);
      rd(3'd5, v); check(v == 32'd0, "R4 read-high not writable", 64'(v), 64'd0);

      // directed corners
      run_cmd(8'h06, 0, 32'h0, 0, 0, 0, 64'h0, 64'h0, 0, 1'b0);                       // R10
      run_cmd(8'hEB, 4, 32'hA1B2_C3D4, 31, 0, 8, 64'h0, 64'h0123_4567_89AB_CDEF, 15, 1'b0); // R4 max
      run_cmd(8'h02, 3, 32'h00_12_34_56, 0, 8, 0, 64'h8877_6655_4433_2211, 64'h0, 1, 1'b0); // R3 full
      run_cmd(8'h02, 1, 32'h0000_00F0, 2, 1, 0, 64'hFFEE_DDCC_BBAA_99A5, 64'h0, 0, 1'b0);  // R3 one byte
      run_cmd(8'h9F, 0, 32'h0, 0, 0, 1, 64'h0, 64'hC300_0000_0000_0000, 2, 1'b0);          // R4 one byte
      run_cmd(8'h0B, 4, 32'h1357_9BDF, 10, 0, 3, 64'h0, 64'hA5A5_5A5A_0F0F_F0F0, 3, 1'b1); // R9

      // constrained random
      for (int t = 0; t < 30; t++) begin
         an   = int'($urandom % 5);
         dm   = (($urandom % 4) == 0) ? 0 : int'($urandom % 32);
         mode = int'($urandom % 3);
         n    = 1 + int'($urandom % 8);
         f    = int'($urandom % 4);
         w    = {$urandom, $urandom};
         r    = {$urandom, $urandom};
         run_cmd(8'($urandom), an, $urandom, dm, (mode == 1) ? n : 0, (mode == 2) ? n : 0,
                 w, r, f, 1'b0);
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule